// File: doc/BRIEF.md
# SRAM Power-Down Handshake Sequencer

This block is a small sub-sequencer inside a power-domain controller. On a `start` pulse it moves the SRAM banks of one power domain either up or down. It drives one power-down line per bank and watches a matching per-bank acknowledge field. It does not report completion until every acknowledge bit has reached the requested level. A bounded wait turns a stuck bank into a timeout error rather than a hang.

When the `HAS_ISO` parameter is set, the sequencer also runs two isolation outputs in a fixed order, with a settling delay of `SETTLE_CYCLES` clock cycles between them. The delay is sized from the clock frequency, for example 50 cycles for about 1 µs at 50 MHz.

- **Power-down:** clock isolation is raised first. After the delay, isolation release is dropped. Only then are the power-down lines set.
- **Power-up:** the power-down lines are cleared and the acknowledge wait completes. Then isolation release is raised, and after the delay clock isolation is dropped.

The parent controller pulses `start` with `dirUp` selecting the direction and waits for `done`.

Top module: `sram_pwr_seq`

## Requirements
- R1: After reset, every bit of `pdnOut` is 1, `clkIsoOut` is 1, `isoRelOut` is 0, and `done` and `timeoutErr` are 0.
- R2: A start with `dirUp`=1 (power-up) clears every bit of `pdnOut`. `done` is not given until every bit of `pdnAck` reads 0.
- R3: A start with `dirUp`=0 (power-down) sets every bit of `pdnOut`. `done` is not given until every bit of `pdnAck` reads 1. An acknowledge field that matches only in some bits keeps the sequencer waiting.
- R4: On power-up with isolation enabled, `isoRelOut` rises only after all acknowledge bits read 0. `clkIsoOut` falls exactly `SETTLE_CYCLES` cycles after `isoRelOut` rises, and `done` follows.
- R5: On power-down with isolation enabled, `clkIsoOut` rises on the accepted start edge. `isoRelOut` falls exactly `SETTLE_CYCLES` cycles later. `pdnOut` is set one cycle after that.
- R6: If the acknowledge field does not match within `TIMEOUT_CYCLES` cycles of the start of the wait, `done` and `timeoutErr` pulse together. On power-up, this is exactly `TIMEOUT_CYCLES` cycles after the accepted start edge.
- R7: After a timeout, `pdnOut`, `clkIsoOut` and `isoRelOut` keep their last driven values. A later run that completes reports `timeoutErr` as 0.
- R8: `done` is a single-cycle pulse, and `timeoutErr` is high only together with `done`. A `start` that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a run; accepted only when idle |
| dirUp | input | 1 | 1 = power up, 0 = power down; sampled with start |
| pdnAck | input | NUM_BANKS | Per-bank power-down acknowledge |
| pdnOut | output | NUM_BANKS | Per-bank power-down request |
| clkIsoOut | output | 1 | SRAM clock isolation, 1 = isolated |
| isoRelOut | output | 1 | SRAM isolation release, 1 = released |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | Set with done when the acknowledge wait expired |

## Verification
The bench gives one bank an acknowledge lag longer than the others, and checks at `done` that the whole field matches. A sequencer that ORs the per-bank match would finish early with a partly acknowledged field.

The bench measures the gaps between the isolation edges and the power-down edge in both directions. Swapped steps, or a delay off by one, show up as a wrong cycle count.

A bank whose acknowledge is stuck forces a timeout. The bench checks the exact cycle of `done`, that the outputs are held, and that the error flag clears on the next good run. A mid-run `start` of the opposite direction must leave the result unchanged, so a sequencer that restarts would report the wrong final state.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic latchDir;
    logic clrPdn;
    logic setPdn;
    logic setClkIso;
    logic clrClkIso;
    logic setIsoRel;
    logic clrIsoRel;
    logic startSettle;
    logic startWait;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE_DN,
    ST_DN_PDN,
    ST_WAIT_ACK,
    ST_SETTLE_UP,
    ST_FINISH
  } seqState_t;

endpackage

// File: rtl/sram_seq_dp.sv
module sram_seq_dp
  import sram_seq_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter bit HAS_ISO        = 1'b1,
  parameter int SETTLE_CYCLES  = 50,
  parameter int TIMEOUT_CYCLES = 50000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic                 dirUp,
  input  logic [NUM_BANKS-1:0] pdnAck,
  output logic [NUM_BANKS-1:0] pdnOut,
  output logic                 clkIsoOut,
  output logic                 isoRelOut,
  output logic                 ackMatch,
  output logic                 settleDone,
  output logic                 waitExpired
);

  localparam int SettleW = $clog2(SETTLE_CYCLES + 1);
  localparam int WaitW   = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [SettleW-1:0] SettleLast = SettleW'(SETTLE_CYCLES - 1);
  localparam logic [WaitW-1:0]   WaitLast   = WaitW'(TIMEOUT_CYCLES - 1);

  logic                 targetUp;
  logic [NUM_BANKS-1:0] pdnReg;
  logic [SettleW-1:0]   settleCnt;
  logic [WaitW-1:0]     waitCnt;

  // Requested direction, latched when a run is accepted.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                targetUp <= 1'b0;
    else if (strobe.latchDir) targetUp <= dirUp;
  end

  // Power-down field is driven as a whole.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pdnReg <= '1;
    else if (strobe.setPdn) pdnReg <= '1;
    else if (strobe.clrPdn) pdnReg <= '0;
  end
  assign pdnOut = pdnReg;

  // All banks must agree with the requested state.
  assign ackMatch = targetUp ? (pdnAck == '0) : (&pdnAck);

  // Settling delay counter, saturates at its last value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   settleCnt <= '0;
    else if (strobe.startSettle) settleCnt <= '0;
    else if (settleCnt != SettleLast) settleCnt <= settleCnt + 1'b1;
  end
  assign settleDone = (settleCnt == SettleLast);

  // Acknowledge wait counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.startWait) waitCnt <= '0;
    else if (waitCnt != WaitLast) waitCnt <= waitCnt + 1'b1;
  end
  assign waitExpired = (waitCnt == WaitLast);

  generate
    if (HAS_ISO) begin : g_iso
      logic clkIsoReg;
      logic isoRelReg;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 clkIsoReg <= 1'b1;
        else if (strobe.setClkIso) clkIsoReg <= 1'b1;
        else if (strobe.clrClkIso) clkIsoReg <= 1'b0;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 isoRelReg <= 1'b0;
        else if (strobe.setIsoRel) isoRelReg <= 1'b1;
        else if (strobe.clrIsoRel) isoRelReg <= 1'b0;
      end

      assign clkIsoOut = clkIsoReg;
      assign isoRelOut = isoRelReg;

      AST_REL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
        $rose(isoRelOut) |-> (pdnOut == '0) && (pdnAck == '0)); // R4
      AST_CLKISO_DROP_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
        $fell(clkIsoOut) |-> isoRelOut); // R4
      AST_PDN_SET_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pdnOut[0]) |-> clkIsoOut && !isoRelOut); // R5
    end else begin : g_noiso
      assign clkIsoOut = 1'b0;
      assign isoRelOut = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter bit HAS_ISO = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dirUp,
  input  logic       ackMatch,
  input  logic       settleDone,
  input  logic       waitExpired,
  output seqStrobe_t strobe,
  output logic       done,
  output logic       timeoutErr
);

  seqState_t state;
  seqState_t stateNext;
  logic      runUp;
  logic      errFlag;
  logic      errSet;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.latchDir = 1'b1;
          if (dirUp) begin
            strobe.clrPdn    = 1'b1;
            strobe.startWait = 1'b1;
            stateNext        = ST_WAIT_ACK;
          end else if (HAS_ISO) begin
            strobe.setClkIso   = 1'b1;
            strobe.startSettle = 1'b1;
            stateNext          = ST_SETTLE_DN;
          end else begin
            strobe.setPdn    = 1'b1;
            strobe.startWait = 1'b1;
            stateNext        = ST_WAIT_ACK;
          end
        end
      end
      ST_SETTLE_DN: begin
        if (settleDone) begin
          strobe.clrIsoRel = 1'b1;
          stateNext        = ST_DN_PDN;
        end
      end
      ST_DN_PDN: begin
        strobe.setPdn    = 1'b1;
        strobe.startWait = 1'b1;
        stateNext        = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        if (ackMatch) begin
          if (runUp && HAS_ISO) begin
            strobe.setIsoRel   = 1'b1;
            strobe.startSettle = 1'b1;
            stateNext          = ST_SETTLE_UP;
          end else begin
            stateNext = ST_FINISH;
          end
        end else if (waitExpired) begin
          errSet    = 1'b1;
          stateNext = ST_FINISH;
        end
      end
      ST_SETTLE_UP: begin
        if (settleDone) begin
          strobe.clrClkIso = 1'b1;
          stateNext        = ST_FINISH;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runUp <= 1'b0;
    else if (strobe.latchDir) runUp <= dirUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                errFlag <= 1'b0;
    else if (strobe.latchDir) errFlag <= 1'b0;
    else if (errSet)          errFlag <= 1'b1;
  end

  assign done       = (state == ST_FINISH);
  assign timeoutErr = done && errFlag;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> done); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) && (state != ST_FINISH) |=> $stable(runUp)); // R8
  AST_STRONG_PDN_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setPdn && strobe.clrPdn)); // R2

endmodule

// File: rtl/sram_pwr_seq.sv
module sram_pwr_seq
  import sram_seq_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter bit HAS_ISO        = 1'b1,
  parameter int SETTLE_CYCLES  = 50,
  parameter int TIMEOUT_CYCLES = 50000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 dirUp,
  input  logic [NUM_BANKS-1:0] pdnAck,
  output logic [NUM_BANKS-1:0] pdnOut,
  output logic                 clkIsoOut,
  output logic                 isoRelOut,
  output logic                 done,
  output logic                 timeoutErr
);

  seqStrobe_t strobe;
  logic       ackMatch;
  logic       settleDone;
  logic       waitExpired;

  sram_seq_ctrl #(
    .HAS_ISO(HAS_ISO)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .dirUp      (dirUp),
    .ackMatch   (ackMatch),
    .settleDone (settleDone),
    .waitExpired(waitExpired),
    .strobe     (strobe),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

  sram_seq_dp #(
    .NUM_BANKS     (NUM_BANKS),
    .HAS_ISO       (HAS_ISO),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dirUp      (dirUp),
    .pdnAck     (pdnAck),
    .pdnOut     (pdnOut),
    .clkIsoOut  (clkIsoOut),
    .isoRelOut  (isoRelOut),
    .ackMatch   (ackMatch),
    .settleDone (settleDone),
    .waitExpired(waitExpired)
  );

endmodule

// File: tb/sram_pwr_seq_tb.sv
module sram_pwr_seq_tb;

  localparam int NB      = 4;
  localparam int SETTLE  = 5;
  localparam int TIMEOUT = 20;
  localparam logic [NB-1:0] ALL1 = '1;

  typedef struct {
    logic          err;
    logic [NB-1:0] pdn;
    logic          clkIso;
    logic          isoRel;
    logic          up;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          dirUp = 1'b0;
  logic [NB-1:0] pdnAck;
  logic [NB-1:0] pdnOut;
  logic          clkIsoOut, isoRelOut, done, timeoutErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int doneCount = 0;
  int doneCyc = 0;
  int startCyc = 0;
  int relRise = 0, relFall = 0, clkRise = 0, clkFall = 0, pdnRise = 0;

  logic [NB-1:0] hist [0:7];
  logic [NB-1:0] slowMask = '0;
  logic [NB-1:0] stuck1 = '0;
  logic [NB-1:0] stuck0 = '0;
  expItem_t expQ[$];

  always #10 clk = ~clk; // 50 MHz

  sram_pwr_seq #(
    .NUM_BANKS(NB), .HAS_ISO(1'b1),
    .SETTLE_CYCLES(SETTLE), .TIMEOUT_CYCLES(TIMEOUT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dirUp(dirUp),
    .pdnAck(pdnAck), .pdnOut(pdnOut), .clkIsoOut(clkIsoOut),
    .isoRelOut(isoRelOut), .done(done), .timeoutErr(timeoutErr)
  );

  // Bank model: fast banks answer after 3 cycles, slow ones after 7.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      for (int k = 0; k < 8; k++) hist[k] <= ALL1;
    end else begin
      hist[0] <= pdnOut;
      for (int k = 1; k < 8; k++) hist[k] <= hist[k-1];
    end
  end
  assign pdnAck = (((hist[2] & ~slowMask) | (hist[6] & slowMask)) & ~stuck0) | stuck1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: edge timestamps and scoreboard comparison at done.
  logic prevRel = 1'b0, prevClk = 1'b1, prevPdn = 1'b1, prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (isoRelOut && !prevRel) relRise = cyc;
      if (!isoRelOut && prevRel) relFall = cyc;
      if (clkIsoOut && !prevClk) clkRise = cyc;
      if (!clkIsoOut && prevClk) clkFall = cyc;
      if (pdnOut[0] && !prevPdn) pdnRise = cyc;
      chk(!(done && prevDone), "R8 done width", int'(done), 0);
      if (done) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(timeoutErr == e.err, "R6/R7 timeoutErr", int'(timeoutErr), int'(e.err));
          chk(pdnOut == e.pdn, "R2/R3/R7 pdnOut", int'(pdnOut), int'(e.pdn));
          chk(clkIsoOut == e.clkIso, "R4/R5/R7 clkIsoOut", int'(clkIsoOut), int'(e.clkIso));
          chk(isoRelOut == e.isoRel, "R4/R5/R7 isoRelOut", int'(isoRelOut), int'(e.isoRel));
          if (!e.err)
            chk(pdnAck == e.pdn, "R2/R3 full ack before done", int'(pdnAck), int'(e.pdn));
        end
        doneCyc = cyc;
        doneCount++;
      end
      prevRel  = isoRelOut;
      prevClk  = clkIsoOut;
      prevPdn  = pdnOut[0];
      prevDone = done;
    end
  end

  // Driver: pushes the expected result and issues the start pulse.
  task automatic runOp(input logic up, input logic expErr, input logic [NB-1:0] expPdn,
                       input logic expClk, input logic expRel, input bit poke);
    expItem_t e;
    int seen;
    int guard;
    e.err = expErr; e.pdn = expPdn; e.clkIso = expClk; e.isoRel = expRel; e.up = up;
    expQ.push_back(e);
    seen = doneCount;
    @(negedge clk);
    start = 1'b1; dirUp = up; startCyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; dirUp = ~up; // R8: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (doneCount == seen && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 500, "watchdog", guard, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pdnOut == ALL1, "R1 pdnOut", int'(pdnOut), int'(ALL1));
    chk(clkIsoOut == 1'b1, "R1 clkIsoOut", int'(clkIsoOut), 1);
    chk(isoRelOut == 1'b0, "R1 isoRelOut", int'(isoRelOut), 0);
    chk(done == 1'b0 && timeoutErr == 1'b0, "R1 done/err", int'({done, timeoutErr}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R4: normal power-up
    runOp(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    chk(clkFall - relRise == SETTLE, "R4 release-to-clock gap", clkFall - relRise, SETTLE);

    // R3/R5: power-down, bank 2 slow
    slowMask = 4'b0100;
    runOp(1'b0, 1'b0, ALL1, 1'b1, 1'b0, 1'b0);
    chk(clkRise == startCyc, "R5 clock isolation on start", clkRise, startCyc);
    chk(relFall - clkRise == SETTLE, "R5 clock-to-release gap", relFall - clkRise, SETTLE);
    chk(pdnRise - relFall == 1, "R5 pdn after release", pdnRise - relFall, 1);

    // R6/R7: power-up with bank 1 stuck at 1 -> timeout, outputs held
    slowMask = '0;
    stuck1 = 4'b0010;
    runOp(1'b1, 1'b1, '0, 1'b1, 1'b0, 1'b0);
    chk(doneCyc - startCyc == TIMEOUT, "R6 timeout cycle", doneCyc - startCyc, TIMEOUT);
    repeat (4) @(negedge clk);
    chk(pdnOut == '0 && clkIsoOut && !isoRelOut, "R7 outputs held after timeout",
        int'({pdnOut, clkIsoOut, isoRelOut}), 2);

    // R7/R8: good power-down clears error; opposite-direction start mid-run ignored
    stuck1 = '0;
    runOp(1'b0, 1'b0, ALL1, 1'b1, 1'b0, 1'b1);

    // R3: power-down while one bank never acks -> timeout, pdn stays set
    stuck0 = 4'b1000;
    runOp(1'b0, 1'b1, ALL1, 1'b1, 1'b0, 1'b0);
    stuck0 = '0;

    // R2/R4: power-up with a slow bank
    slowMask = 4'b0001;
    runOp(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    chk(clkFall - relRise == SETTLE, "R4 gap with slow bank", clkFall - relRise, SETTLE);
    chk(expQ.size() == 0, "R8 scoreboard drained", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule